// File: doc/BRIEF.md
# Per-Pin Input Glitch Filter with Shared Sampling Divider

This block cleans up slow external input levels before they reach edge or level detection. Every raw pin first passes a two-flop synchroniser into the peripheral clock domain. A pin whose filter is switched on updates its output only when two successive sampling instants see the same synchronised level. A level that appears at just one sampling instant, such as a glitch, never reaches the output. A pin whose filter is switched off passes its synchronised level through one register.

Each pin selects its own sampling rate. It can sample on every peripheral clock edge, or it can sample on a slow tick from a single divider that all pins share. The divider value is a 24-bit field. The slow tick repeats every 2 × (value + 1) clock cycles, so the longest spacing is 2^25 cycles. One divider value governs every pin that selects the slow tick. When the value changes, the divider count starts again from zero. Configuration is presented as plain input vectors, with no register bus in front of them.

Top module: `debounce_bank`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every bit of `pin_filt` is 0.
- R2: A pin with `flt_en` bit clear shows its raw level on `pin_filt` three clock edges after the level is applied, whatever its `slow_sel` bit is.
- R3: The shared divider produces one slow tick every 2 × (`div_value` + 1) clock cycles. A change of `div_value` restarts the count from zero, so the first slow tick after the change comes at the 2 × (`div_value` + 1)-th edge following the edge that sees the new value.
- R4: A filtered pin changes its output only when two consecutive sampling instants see the same synchronised level. A level present at only one sampling instant never appears on the output.
- R5: A filtered pin with `slow_sel` bit clear samples on every clock edge. A new level held steady therefore appears four edges after it is applied, and a one-cycle pulse is rejected while a two-cycle pulse passes.
- R6: All pins that select the slow tick share one divider value and change on the same edge when they see the same input history.
- R7: The divider count stays within its programmed range at every `div_value`, up to all ones. With the largest value, no filtered slow pin changes within thousands of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_value | input | DIVW (24) | Shared divider setting; slow tick period is 2 × (value + 1) cycles |
| flt_en | input | NPINS (32) | Per-pin filter enable |
| slow_sel | input | NPINS (32) | Per-pin choice: 1 = slow divided tick, 0 = every clock |
| pin_raw | input | NPINS (32) | Asynchronous raw pin levels |
| pin_filt | output | NPINS (32) | Filtered pin levels |

## Verification
The assertions assume that `flt_en`, `slow_sel` and `div_value` change only between clock edges and are otherwise held steady. They also assume that `pin_raw` is treated as asynchronous and is seen only through the synchroniser. The bench drives every input on the falling edge, so each edge sees settled values. The bench changes `div_value` only to a value different from the current one, so that each change gives a known restart point. Random batches keep the enable vectors fixed within a batch, and every batch starts with a settling interval at a constant level.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
   // Terminal count of the shared divider: period is 2*(div+1) cycles.
   function automatic logic [24:0] dbn_limit_24(input logic [23:0] div);
      return {div, 1'b1};
   endfunction
endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("dbn_sync: STAGES must be at least 1");
   end
   if (W < 1) begin : g_bad_width
      $error("dbn_sync: W must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= '0;
         else        stg <= d;
      end
      assign q = stg;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= '0;
         else        stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/dbn_tick_div.sv
module dbn_tick_div #(
   parameter int DIVW = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DIVW-1:0] div_value,
   output logic            tick
);
   localparam int CW = DIVW + 1;

   if (DIVW < 1) begin : g_bad_divw
      $error("dbn_tick_div: DIVW must be at least 1");
   end

   logic [DIVW-1:0] div_q;
   logic [CW-1:0]   cnt;
   logic [CW-1:0]   limit;
   logic            restart;

   assign limit   = {div_q, 1'b1};
   assign restart = (div_value != div_q);
   assign tick    = !restart && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt   <= '0;
      end else if (restart) begin
         div_q <= div_value;
         cnt   <= '0;
      end else if (cnt == limit) begin
         cnt   <= '0;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

   // R7: counter never runs past the programmed terminal count
   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> cnt <= limit);
   // R3: a new divider value restarts the count from zero
   a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> cnt == '0);
   // R3: period is at least two cycles, so ticks never come back to back
   a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/dbn_pin_filter.sv
module dbn_pin_filter (
   input  logic clk,
   input  logic rst_n,
   input  logic flt_on,
   input  logic smp_tick,
   input  logic din,
   output logic dout
);
   logic samp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp <= 1'b0;
         dout <= 1'b0;
      end else if (!flt_on) begin
         samp <= din;
         dout <= din;
      end else if (smp_tick) begin
         samp <= din;
         if (din == samp) dout <= din;
      end
   end

   // R4: no output movement between sampling instants
   a_r4_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_on && !smp_tick) |=> $stable(dout));
   // R4: a level seen at one instant only cannot pass
   a_r4_need_match: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_on && smp_tick && (din != samp)) |=> $stable(dout));
   // R2: unfiltered pins follow the synchronised level one edge later
   a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_on |=> dout == $past(din));
endmodule

// File: rtl/debounce_bank.sv
module debounce_bank #(
   parameter int NPINS       = 32,
   parameter int DIVW        = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIVW-1:0]  div_value,
   input  logic [NPINS-1:0] flt_en,
   input  logic [NPINS-1:0] slow_sel,
   input  logic [NPINS-1:0] pin_raw,
   output logic [NPINS-1:0] pin_filt
);
   if (NPINS < 1) begin : g_bad_npins
      $error("debounce_bank: NPINS must be at least 1");
   end

   logic [NPINS-1:0] pin_sync;
   logic [NPINS-1:0] pin_tick;
   logic             slow_tick;

   dbn_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (pin_sync)
   );

   dbn_tick_div #(.DIVW(DIVW)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_value (div_value),
      .tick      (slow_tick)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign pin_tick[i] = slow_sel[i] ? slow_tick : 1'b1;
      dbn_pin_filter u_flt (
         .clk      (clk),
         .rst_n    (rst_n),
         .flt_on   (flt_en[i]),
         .smp_tick (pin_tick[i]),
         .din      (pin_sync[i]),
         .dout     (pin_filt[i])
      );
   end

   // R1: outputs are low on the first cycle out of reset
   a_r1_reset_low: assert property (@(posedge clk)
      !rst_n |=> pin_filt == '0);
   // R5: pins off the slow tick sample on every edge
   a_r5_fast_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_tick | slow_sel) == {NPINS{1'b1}});
endmodule

// File: tb/debounce_bank_test.sv
module debounce_bank_test;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 32;
   localparam int DW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] div_value = '0;
   logic [NP-1:0] flt_en = '0;
   logic [NP-1:0] slow_sel = '0;
   logic [NP-1:0] pin_raw = '0;
   logic [NP-1:0] pin_filt;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   debounce_bank #(.NPINS(NP), .DIVW(DW), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .div_value(div_value), .flt_en(flt_en),
      .slow_sel(slow_sel), .pin_raw(pin_raw), .pin_filt(pin_filt)
   );

   task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic nwait(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   function automatic logic [NP-1:0] merge(input logic [NP-1:0] m, input logic [NP-1:0] a,
                                           input logic [NP-1:0] b);
      return (m & a) | (~m & b);
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [NP-1:0] h1, h2, h3, h4, expf, x, mask, base;
      int p;
      void'($urandom(32'd4321));

      // R1 reset state
      nwait(3);
      chk("R1 in reset", pin_filt, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", pin_filt, '0);

      // Directed: pin0,pin5 slow filtered; pin1 fast filtered; pin2 bypass
      div_value = 24'd5;
      flt_en    = 32'h0000_0023;
      slow_sel  = 32'h0000_0025;
      pin_raw   = '0;
      nwait(100);
      chk("R1 settled low", pin_filt, '0);

      // R3/R5/R2/R6 latency, divider changed together with input
      div_value = 24'd3;          // period 8
      p = 8;
      pin_raw = 32'h0000_0027;
      nwait(2);
      chk("R2 bypass before", pin_filt & 32'h4, 32'h0);
      nwait(1);
      chk("R2 bypass at 3 edges", pin_filt & 32'h4, 32'h4);
      chk("R5 fast before", pin_filt & 32'h2, 32'h0);
      nwait(1);
      chk("R5 fast at 4 edges", pin_filt & 32'h2, 32'h2);
      nwait(2*p - 4);
      chk("R3 slow before 2P", pin_filt & 32'h21, 32'h0);
      nwait(1);
      chk("R3 R6 slow after 2P", pin_filt & 32'h21, 32'h21);
      nwait(10);

      // R4 slow one-cycle glitch rejected
      pin_raw = 32'h0000_0026;
      @(negedge clk);
      pin_raw = 32'h0000_0027;
      nwait(4*p);
      chk("R4 slow glitch", pin_filt & 32'h21, 32'h21);

      // R5 fast one-cycle pulse rejected
      pin_raw = 32'h0000_0025;
      @(negedge clk);
      pin_raw = 32'h0000_0027;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk("R5 fast 1-cycle pulse", pin_filt & 32'h2, 32'h2);
      end

      // R5 fast two-cycle pulse passes on edges 4 and 5
      pin_raw = 32'h0000_0025;
      nwait(2);
      pin_raw = 32'h0000_0027;
      nwait(2);
      chk("R5 fast 2-cycle pulse low", pin_filt & 32'h2, 32'h0);
      nwait(1);
      chk("R5 fast 2-cycle pulse held", pin_filt & 32'h2, 32'h0);
      nwait(1);
      chk("R5 fast 2-cycle pulse back", pin_filt & 32'h2, 32'h2);

      // R7 largest divider: no slow change for a long time
      div_value = {DW{1'b1}};
      pin_raw = 32'h0000_0006;
      nwait(3000);
      chk("R7 max divider holds", pin_filt & 32'h21, 32'h21);

      // R2 bypass ignores slow_sel
      div_value = 24'd2;
      flt_en = '0;
      slow_sel = '1;
      pin_raw = 32'hA5A5_0F0F;
      nwait(3);
      chk("R2 bypass with slow_sel", pin_filt, 32'hA5A5_0F0F);

      // Random batches on fast sampling
      for (int b = 0; b < 4; b++) begin
         flt_en   = $urandom;
         slow_sel = $urandom & ~flt_en;
         base     = $urandom;
         pin_raw  = base;
         nwait(8);
         chk("R4 R5 batch settle", pin_filt, base);
         h1 = base; h2 = base; h3 = base; h4 = base; expf = base;
         for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            mask = ~(h3 ^ h4);
            expf = merge(mask, h3, expf);
            chk("R2 R4 R5 random", pin_filt, merge(flt_en, expf, h3));
            x = h1 ^ ($urandom & $urandom & $urandom);
            pin_raw = x;
            h4 = h3; h3 = h2; h2 = h1; h1 = x;
         end
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule